// File: doc/BRIEF.md
# Paced Successive-Approximation Conversion Controller

This block is the digital half of a 7-bit analog-to-digital converter. The other half is outside the chip: a DAC and an analog comparator. The block drives a trial code to the DAC. It reads back, through a two-stage synchronizer, whether the input voltage is at or above the DAC voltage. It then resolves the code one bit at a time, starting from the most significant bit. Each trial code is held for a fixed number of clocks, so the DAC, the comparator and the synchronizer can all settle before the bit is decided.

Conversions are paced by a free-running frame divider. With the default of 120000 clocks at 12 MHz, a new conversion starts 100 times per second. When a conversion finishes, the final code is copied into a result register and stays there for the whole of the following frame. On that same clock, an active-low completion strobe goes low for one cycle.

A pause input, also synchronized, is looked at only when a new frame is due. If pause is raised during a conversion, that conversion still runs to the end. After that the block stays idle until pause is released.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While `rst` is high (synchronous reset), `vc_out` and `result_out` are 0 and `done_n` is 1.
- R2: A conversion first drives 0x40 on `vc_out`. After each settling interval it keeps the bit under test if `cmp_in` is high (input ≥ trial code) and clears it otherwise. It then sets the next lower bit, so every trial code seen on `vc_out` carries the bits decided so far plus one new bit.
- R3: Every trial code stays on `vc_out` for exactly `SETTLE_CLKS` clocks. `cmp_in` passes through two flip-flops before it is used, so the bit decision (and the completion strobe) comes `7*SETTLE_CLKS` clocks after the first trial code appears.
- R4: The published code equals the input expressed in LSBs of full scale: input 0 gives 0x00, full scale gives 0x7F, and codes in between map exactly. On the strobe cycle, `result_out` equals `vc_out`.
- R5: Without pause, conversions start every `FRAME_CLKS` clocks, so completion strobes are exactly `FRAME_CLKS` clocks apart. The defaults give 100 Hz from a 12 MHz clock.
- R6: `result_out` changes only in the cycle in which `done_n` is low. It holds its value through the whole next frame while `vc_out` steps through trials.
- R7: `done_n` goes low for exactly one clock per completed conversion, in the same cycle that `result_out` takes the new code.
- R8: If `pause_in` is raised while a conversion is running, that conversion still completes and strobes. After that, no new conversion starts, and `vc_out` holds its value, until `pause_in` falls. Conversions then resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (12 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Asynchronous comparator output, high when input ≥ DAC voltage |
| pause_in | input | 1 | Asynchronous hold request, active high |
| vc_out | output | 7 | Current trial code driven to the DAC |
| result_out | output | 7 | Last completed conversion, held for a frame |
| done_n | output | 1 | Active-low one-clock completion strobe |

## Verification
A corrupted bit mask or trial register shows up on `vc_out` within one settling interval, as a trial value outside the expected binary-search path. It also shows up at the next strobe as a wrong published code. A settling counter or synchronizer that is off by a cycle moves the first strobe away from `7*SETTLE_CLKS` clocks after the first trial. A stuck or misdecoded controller state shows within one frame, as a missing or doubled strobe, a result that changes outside the strobe, or a conversion that starts while pause is held.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } ctl_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_START = 2'd1,
        OP_JUDGE = 2'd2
    } dp_op_e;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst) stage_q[i] <= '0;
            else     stage_q[i] <= stage_d[i];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sar_frame_timer.sv
module sar_frame_timer #(
    parameter int FRAME_CLKS = 120000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CNT_W = (FRAME_CLKS > 1) ? $clog2(FRAME_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CLKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == LAST) tmr_d.cnt = '0;
        else                   tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign tick_o = (tmr_q.cnt == LAST);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
    import sar_adc_pkg::*;
#(
    parameter int WIDTH       = 7,
    parameter int SETTLE_CLKS = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  dp_op_e           op_i,
    input  logic             cmp_i,
    output logic             settled_o,
    output logic             last_bit_o,
    output logic [WIDTH-1:0] vc_o,
    output logic [WIDTH-1:0] result_o
);
    localparam int SET_W = $clog2(SETTLE_CLKS + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CLKS - 1);
    localparam logic [WIDTH-1:0] TOP_BIT  = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] vc;
        logic [WIDTH-1:0] mask;
        logic [WIDTH-1:0] result;
        logic [SET_W-1:0] wait_cnt;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [WIDTH-1:0] decided;

    always_comb begin
        dp_d    = dp_q;
        decided = cmp_i ? dp_q.vc : (dp_q.vc & ~dp_q.mask);
        unique case (op_i)
            OP_START: begin
                dp_d.vc       = TOP_BIT;
                dp_d.mask     = TOP_BIT;
                dp_d.wait_cnt = '0;
            end
            OP_JUDGE: begin
                dp_d.wait_cnt = '0;
                if (dp_q.mask[0]) begin
                    dp_d.vc     = decided;
                    dp_d.result = decided;
                end else begin
                    dp_d.mask = dp_q.mask >> 1;
                    dp_d.vc   = decided | (dp_q.mask >> 1);
                end
            end
            default: begin
                if (dp_q.wait_cnt != SET_LAST)
                    dp_d.wait_cnt = dp_q.wait_cnt + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign settled_o  = (dp_q.wait_cnt == SET_LAST);
    assign last_bit_o = dp_q.mask[0];
    assign vc_o       = dp_q.vc;
    assign result_o   = dp_q.result;
endmodule

// File: rtl/sar_controller.sv
module sar_controller
    import sar_adc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   pause_i,
    input  logic   settled_i,
    input  logic   last_bit_i,
    output dp_op_e op_o,
    output logic   done_n_o,
    output logic   idle_o
);
    typedef struct packed {
        ctl_state_e state;
        logic       done_n;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done_n = 1'b1;
        op_o         = OP_NONE;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (tick_i && !pause_i) begin
                    op_o        = OP_START;
                    ctl_d.state = ST_CONV;
                end
            end
            ST_CONV: begin
                if (settled_i) begin
                    op_o = OP_JUDGE;
                    if (last_bit_i) begin
                        ctl_d.state  = ST_IDLE;
                        ctl_d.done_n = 1'b0;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state  <= ST_IDLE;
            ctl_q.done_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done_n_o = ctl_q.done_n;
    assign idle_o   = (ctl_q.state == ST_IDLE);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int WIDTH       = 7,
    parameter int FRAME_CLKS  = 120000,
    parameter int SETTLE_CLKS = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_in,
    input  logic             pause_in,
    output logic [WIDTH-1:0] vc_out,
    output logic [WIDTH-1:0] result_out,
    output logic             done_n
);
    localparam int SYNC_STAGES = 2;

    logic [1:0] sync_bus;
    logic       cmp_s, pause_s, tick, settled, last_bit, ctl_idle;
    dp_op_e     op;

    sar_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i({pause_in, cmp_in}),
        .sync_o (sync_bus)
    );
    assign cmp_s   = sync_bus[0];
    assign pause_s = sync_bus[1];

    sar_frame_timer #(.FRAME_CLKS(FRAME_CLKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick_o(tick)
    );

    sar_controller u_ctl (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .pause_i   (pause_s),
        .settled_i (settled),
        .last_bit_i(last_bit),
        .op_o      (op),
        .done_n_o  (done_n),
        .idle_o    (ctl_idle)
    );

    sar_datapath #(.WIDTH(WIDTH), .SETTLE_CLKS(SETTLE_CLKS)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op),
        .cmp_i     (cmp_s),
        .settled_o (settled),
        .last_bit_o(last_bit),
        .vc_o      (vc_out),
        .result_o  (result_out)
    );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int WIDTH = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] vc,
    input logic [WIDTH-1:0] result,
    input logic             done_n,
    input logic             idle
);
    p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        !done_n |=> done_n);

    p_result_only_at_done_r6: assert property (@(posedge clk) disable iff (rst)
        (result != $past(result)) |-> !done_n);

    p_result_is_final_trial_r4: assert property (@(posedge clk) disable iff (rst)
        !done_n |-> (result == vc));

    p_idle_holds_vc_r8: assert property (@(posedge clk) disable iff (rst)
        (idle && $past(idle)) |-> $stable(vc));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .vc    (vc_out),
    .result(result_out),
    .done_n(done_n),
    .idle  (ctl_idle)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
    localparam int W      = 7;
    localparam int FRAME  = 100;
    localparam int SETTLE = 6;
    localparam int CONV   = 7 * SETTLE;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pause = 1'b0;
    logic         cmp;
    logic [W-1:0] vin = '0;
    logic [W-1:0] vc, result;
    logic         done_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    // comparator model: high when input is at or above the DAC code
    always_comb cmp = (vin >= vc);

    sar_adc_ctrl #(.WIDTH(W), .FRAME_CLKS(FRAME), .SETTLE_CLKS(SETTLE)) uut (
        .clk(clk), .rst(rst), .cmp_in(cmp), .pause_in(pause),
        .vc_out(vc), .result_out(result), .done_n(done_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(input int lim, output bit seen, output int n);
        seen = 1'b0;
        n = 0;
        while (!seen && n < lim) begin
            @(negedge clk);
            n++;
            if (!done_n) seen = 1'b1;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(vc == 0,      "R1 vc in reset",     vc, 0);
        check(result == 0,  "R1 result in reset", result, 0);
        check(done_n == 1,  "R1 done_n in reset", done_n, 1);
        rst = 1'b0;
    endtask

    task automatic t_convert(input logic [W-1:0] v);
        bit seen; int n; bit hold_ok; bit strobe_ok; logic [W-1:0] held;
        vin = v;
        wait_done(2 * FRAME, seen, n);
        wait_done(2 * FRAME, seen, n);
        check(seen, "R5 strobe present", seen, 1);
        check(result == v, "R4 published code", result, v);
        check(vc == v, "R2 final trial code", vc, v);
        held = result;
        @(negedge clk);
        check(done_n == 1, "R7 strobe one clock", done_n, 1);
        hold_ok = 1'b1; strobe_ok = 1'b1;
        for (int k = 2; k < FRAME; k++) begin
            @(negedge clk);
            if (result != held) hold_ok = 1'b0;
            if (!done_n) strobe_ok = 1'b0;
        end
        check(hold_ok, "R6 result held over frame", result, held);
        check(strobe_ok, "R7 no extra strobe", strobe_ok, 1);
        @(negedge clk);
        check(done_n == 0, "R5 strobe period", done_n, 0);
    endtask

    task automatic t_trials();
        logic [W-1:0] exp_seq [7] = '{7'h40, 7'h60, 7'h50, 7'h58, 7'h54, 7'h56, 7'h55};
        logic [W-1:0] prev; int idx [7]; logic [W-1:0] got [7];
        int nchg; int done_at; bit seq_ok; bit gap_ok;
        vin = 7'h55;
        prev = vc; nchg = 0; done_at = -1;
        for (int i = 0; i < FRAME + 5; i++) begin
            @(negedge clk);
            if (vc != prev && nchg < 7) begin
                got[nchg] = vc; idx[nchg] = i; nchg++;
            end
            prev = vc;
            if (!done_n && done_at < 0) done_at = i;
        end
        check(nchg == 7, "R2 number of trial steps", nchg, 7);
        seq_ok = 1'b1; gap_ok = 1'b1;
        for (int j = 0; j < 7; j++) begin
            if (j < nchg && got[j] != exp_seq[j]) seq_ok = 1'b0;
            if (j > 0 && j < nchg && idx[j] - idx[j-1] != SETTLE) gap_ok = 1'b0;
        end
        check(seq_ok, "R2 MSB-first trial path", got[0], exp_seq[0]);
        check(gap_ok, "R3 trial hold length", idx[1] - idx[0], SETTLE);
        check(done_at - idx[0] == CONV, "R3 strobe delay from first trial",
              done_at - idx[0], CONV);
        check(result == 7'h55, "R4 code 0x55", result, 7'h55);
    endtask

    task automatic t_pause();
        bit seen; int n; bit quiet; logic [W-1:0] vc_hold;
        vin = 7'h33;
        wait_done(2 * FRAME, seen, n);
        repeat (FRAME - CONV + 5) @(negedge clk);
        pause = 1'b1;
        wait_done(CONV, seen, n);
        check(seen, "R8 running conversion completes", seen, 1);
        check(result == 7'h33, "R8 completed code", result, 7'h33);
        vc_hold = vc;
        quiet = 1'b1;
        for (int k = 0; k < 3 * FRAME; k++) begin
            @(negedge clk);
            if (!done_n || vc != vc_hold) quiet = 1'b0;
        end
        check(quiet, "R8 idle while paused", vc, vc_hold);
        vin = 7'h0C;
        pause = 1'b0;
        wait_done(2 * FRAME, seen, n);
        check(seen, "R8 resumes after release", seen, 1);
        check(result == 7'h0C, "R8 code after resume", result, 7'h0C);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 60000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 60000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_convert(7'h00);
        t_convert(7'h7F);
        t_convert(7'h2A);
        t_convert(7'h40);
        t_convert(7'h3F);
        t_trials();
        t_pause();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule